// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Capacity Sharing

This block holds in-flight instructions for several hardware threads. Each thread has its own program-ordered queue, and every entry carries a sequence tag, a completion flag and a squash flag. New entries arrive on a valid/ready allocate stream. Completions are posted by sequence tag. Each thread retires from its oldest entry once that entry has completed. Squash walking is done outside this block. The outside block only marks entries through the completion port.

How much of the shared capacity a single thread may hold is set by a policy input and an active-thread mask. Under the dynamic policy any thread may use the whole buffer. The partitioned policy divides the buffer evenly among the active threads. The threshold policy gives each thread a fixed cap. Per-thread limits sit in registers and follow the policy and mask with one cycle of delay.

Back-pressure rules: `alloc_ready` is low only when the whole buffer is full, and nothing is taken while it is low. If a request arrives while `alloc_ready` is high but the requesting thread has no free slot left under its limit, the request is dropped and `alloc_err` is raised in that same cycle.

Top module: `mt_rob`

## Requirements
- R1: With `cfg_policy` = 0 (dynamic, and code 3 behaves the same way), every thread's limit equals DEPTH.
- R2: With `cfg_policy` = 1 (partitioned), every thread's limit is DEPTH divided by the number of set bits in `active_mask`, using integer division. When no bit is set, the divisor is NTHR.
- R3: With `cfg_policy` = 2 (threshold), every thread's limit is THRESH. The exception is when exactly one mask bit is set: that active thread then gets DEPTH.
- R4: Limits reset to DEPTH. A change on `cfg_policy` or `active_mask` reaches the free counts one clock later.
- R5: Thread t's free count (field t of `thr_free`, CNTW bits wide) is its limit minus its occupancy, clamped at zero. `total_free` is DEPTH minus the summed occupancy.
- R6: `alloc_ready` is low exactly when `total_free` is zero. An accepted allocation raises the thread's occupancy and the total occupancy by one each.
- R7: If `alloc_valid` and `alloc_ready` are both high but the thread's free count is zero, the entry is not stored and `alloc_err` is high in that cycle. No other allocation ever raises `alloc_err`.
- R8: `head_ready[t]` is high only when thread t holds an entry and its oldest entry has completed. A completion (`done_valid`) marks the entry of thread `done_tid` whose tag equals `done_seq`.
- R9: `commit_ok` is high when some thread with its `active_mask` bit set has `head_ready` high. A ready head on an inactive thread does not count.
- R10: `retire_req[t]` removes thread t's oldest entry only when `head_ready[t]` is high, and is ignored otherwise. `head_seq` field t (SEQW bits) shows the oldest tag, and entries leave in allocation order.
- R11: A completion that has `done_squash` high also sets the entry's squash flag. `head_squashed[t]` shows that flag for the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_policy | input | 2 | Sharing policy: 0 dynamic, 1 partitioned, 2 threshold, 3 dynamic |
| active_mask | input | NTHR | One bit per running thread |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Buffer not full |
| alloc_tid | input | TIDW | Thread of the request |
| alloc_seq | input | SEQW | Sequence tag of the new entry |
| alloc_err | output | 1 | Request rejected by the thread limit |
| done_valid | input | 1 | Completion strobe |
| done_tid | input | TIDW | Thread of the completion |
| done_seq | input | SEQW | Tag being completed |
| done_squash | input | 1 | Also mark the entry squashed |
| retire_req | input | NTHR | Per-thread retire request |
| head_ready | output | NTHR | Oldest entry completed, per thread |
| head_seq | output | NTHR*SEQW | Oldest tag, per thread |
| head_squashed | output | NTHR | Squash flag of oldest entry, per thread |
| commit_ok | output | 1 | Some active thread can retire |
| thr_free | output | NTHR*CNTW | Free slots under each thread's limit |
| total_free | output | CNTW | Free slots in the whole buffer |

## Verification
The bench drives the thread-limit rejection while the buffer still has room. A design that confused the per-thread check with the global one would store the entry, or would drop `alloc_ready` when it should raise `alloc_err`. It shrinks a limit below a thread's current occupancy, which exposes a free count that wraps around instead of clamping at zero. It also completes a non-head entry before the head, so a design that reports readiness from any completed entry would retire out of order.

The bench also raises a retire request on a head that has not completed, and checks that nothing leaves. It clears the mask bit of a thread whose head is ready, and checks that `commit_ok` falls. It steps through each policy, including the single-active-thread threshold case and the empty-mask partition case.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    POL_DYN  = 2'd0,
    POL_PART = 2'd1,
    POL_THR  = 2'd2,
    POL_ALT  = 2'd3
  } policy_e;
endpackage

// File: rtl/rob_limits.sv
module rob_limits
  import rob_pkg::*;
#(
  parameter int NTHR   = 2,
  parameter int DEPTH  = 8,
  parameter int THRESH = 6,
  parameter int CNTW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           policy,
  input  logic [NTHR-1:0]      active,
  output logic [NTHR*CNTW-1:0] lim_flat
);
  localparam int NW = $clog2(NTHR + 1);

  logic [NW-1:0]   n_act;
  logic [CNTW-1:0] part_share;

  always_comb begin
    n_act      = NW'($countones(active));
    part_share = CNTW'(DEPTH / NTHR);
    for (int k = 1; k <= NTHR; k++)
      if (n_act == NW'(k)) part_share = CNTW'(DEPTH / k);
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_lim
    logic [CNTW-1:0] nxt;
    always_comb begin
      case (policy_e'(policy))
        POL_PART: nxt = part_share;
        POL_THR:  nxt = (n_act == NW'(1) && active[t]) ? CNTW'(DEPTH) : CNTW'(THRESH);
        default:  nxt = CNTW'(DEPTH);
      endcase
    end
    always_ff @(posedge clk) begin
      if (!rst_n) lim_flat[t*CNTW +: CNTW] <= CNTW'(DEPTH);
      else        lim_flat[t*CNTW +: CNTW] <= nxt;
    end
  end

  p_dyn_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(policy) == 2'd0) |-> (lim_flat == {NTHR{CNTW'(DEPTH)}}));

  p_thr_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(policy) == 2'd2 && $countones($past(active)) != 1)
      |-> (lim_flat == {NTHR{CNTW'(THRESH)}}));
endmodule

// File: rtl/rob_thread_q.sv
module rob_thread_q #(
  parameter int DEPTH = 8,
  parameter int SEQW  = 8,
  parameter int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [SEQW-1:0] push_seq,
  input  logic            done,
  input  logic [SEQW-1:0] done_seq,
  input  logic            done_squash,
  input  logic            pop,
  output logic [CNTW-1:0] occ,
  output logic            head_rdy,
  output logic [SEQW-1:0] head_seq,
  output logic            head_sq
);
  logic [SEQW-1:0]  seq_m [DEPTH];
  logic [DEPTH-1:0] vld_m, rdy_m, sq_m;
  logic [PTRW-1:0]  hd, tl;

  function automatic logic [PTRW-1:0] wrap_inc(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + PTRW'(1);
  endfunction

  assign head_rdy = (occ != '0) && rdy_m[hd];
  assign head_seq = seq_m[hd];
  assign head_sq  = sq_m[hd];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd    <= '0;
      tl    <= '0;
      occ   <= '0;
      vld_m <= '0;
      rdy_m <= '0;
      sq_m  <= '0;
      for (int i = 0; i < DEPTH; i++) seq_m[i] <= '0;
    end else begin
      if (done)
        for (int i = 0; i < DEPTH; i++)
          if (vld_m[i] && seq_m[i] == done_seq) begin
            rdy_m[i] <= 1'b1;
            if (done_squash) sq_m[i] <= 1'b1;
          end
      if (pop) begin
        vld_m[hd] <= 1'b0;
        hd        <= wrap_inc(hd);
      end
      if (push) begin
        seq_m[tl] <= push_seq;
        vld_m[tl] <= 1'b1;
        rdy_m[tl] <= 1'b0;
        sq_m[tl]  <= 1'b0;
        tl        <= wrap_inc(tl);
      end
      occ <= occ + CNTW'(push) - CNTW'(pop);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (occ != CNTW'(DEPTH)));

  p_pop_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ != '0 && rdy_m[hd]));

  p_occ_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (occ == $past(occ) + CNTW'(1)));
endmodule

// File: rtl/mt_rob.sv
module mt_rob #(
  parameter int NTHR   = 2,
  parameter int DEPTH  = 8,
  parameter int SEQW   = 8,
  parameter int THRESH = 6,
  parameter int TIDW   = (NTHR > 1) ? $clog2(NTHR) : 1,
  parameter int CNTW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_policy,
  input  logic [NTHR-1:0]      active_mask,
  input  logic                 alloc_valid,
  output logic                 alloc_ready,
  input  logic [TIDW-1:0]      alloc_tid,
  input  logic [SEQW-1:0]      alloc_seq,
  output logic                 alloc_err,
  input  logic                 done_valid,
  input  logic [TIDW-1:0]      done_tid,
  input  logic [SEQW-1:0]      done_seq,
  input  logic                 done_squash,
  input  logic [NTHR-1:0]      retire_req,
  output logic [NTHR-1:0]      head_ready,
  output logic [NTHR*SEQW-1:0] head_seq,
  output logic [NTHR-1:0]      head_squashed,
  output logic                 commit_ok,
  output logic [NTHR*CNTW-1:0] thr_free,
  output logic [CNTW-1:0]      total_free
);
  logic [NTHR*CNTW-1:0] lim_flat;
  logic [CNTW-1:0]      occ_v [NTHR];
  logic [NTHR-1:0]      push_v, pop_v;
  logic [CNTW-1:0]      total_occ;
  logic                 tid_ok, room, accept;

  rob_limits #(.NTHR(NTHR), .DEPTH(DEPTH), .THRESH(THRESH), .CNTW(CNTW)) u_limits (
    .clk(clk), .rst_n(rst_n), .policy(cfg_policy), .active(active_mask),
    .lim_flat(lim_flat)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CNTW-1:0] lim_t;
    assign lim_t = lim_flat[t*CNTW +: CNTW];
    assign thr_free[t*CNTW +: CNTW] = (lim_t > occ_v[t]) ? lim_t - occ_v[t] : '0;
    assign push_v[t] = accept && (alloc_tid == TIDW'(t));
    assign pop_v[t]  = retire_req[t] && head_ready[t];

    rob_thread_q #(.DEPTH(DEPTH), .SEQW(SEQW), .CNTW(CNTW)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(push_v[t]), .push_seq(alloc_seq),
      .done(done_valid && done_tid == TIDW'(t)), .done_seq(done_seq),
      .done_squash(done_squash),
      .pop(pop_v[t]),
      .occ(occ_v[t]), .head_rdy(head_ready[t]),
      .head_seq(head_seq[t*SEQW +: SEQW]), .head_sq(head_squashed[t])
    );
  end

  always_comb begin
    total_occ = '0;
    for (int t = 0; t < NTHR; t++) total_occ = total_occ + occ_v[t];
    tid_ok = 1'b0;
    room   = 1'b0;
    for (int t = 0; t < NTHR; t++)
      if (alloc_tid == TIDW'(t)) begin
        tid_ok = 1'b1;
        room   = thr_free[t*CNTW +: CNTW] != '0;
      end
  end

  assign total_free  = CNTW'(DEPTH) - total_occ;
  assign alloc_ready = total_occ != CNTW'(DEPTH);
  assign accept      = alloc_valid && alloc_ready && tid_ok && room;
  assign alloc_err   = alloc_valid && alloc_ready && !(tid_ok && room);
  assign commit_ok   = |(head_ready & active_mask);

  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |=> (total_free == $past(total_free) + CNTW'($countones($past(pop_v)))));

  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && pop_v == '0) |=> (total_free == '0));
endmodule

// File: tb/test_mt_rob.sv
`timescale 1ns/1ps
module test_mt_rob;
  localparam int NTHR = 2, DEPTH = 8, SEQW = 8, THRESH = 6;
  localparam int TIDW = 1, CNTW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_policy = 2'd0;
  logic [NTHR-1:0] active_mask = '1;
  logic alloc_valid = 1'b0, alloc_ready, alloc_err;
  logic [TIDW-1:0] alloc_tid = '0;
  logic [SEQW-1:0] alloc_seq = '0;
  logic done_valid = 1'b0, done_squash = 1'b0;
  logic [TIDW-1:0] done_tid = '0;
  logic [SEQW-1:0] done_seq = '0;
  logic [NTHR-1:0] retire_req = '0;
  logic [NTHR-1:0] head_ready, head_squashed;
  logic [NTHR*SEQW-1:0] head_seq;
  logic commit_ok;
  logic [NTHR*CNTW-1:0] thr_free;
  logic [CNTW-1:0] total_free;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mt_rob #(.NTHR(NTHR), .DEPTH(DEPTH), .SEQW(SEQW), .THRESH(THRESH)) i_mt_rob (
    .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy), .active_mask(active_mask),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tid(alloc_tid),
    .alloc_seq(alloc_seq), .alloc_err(alloc_err), .done_valid(done_valid),
    .done_tid(done_tid), .done_seq(done_seq), .done_squash(done_squash),
    .retire_req(retire_req), .head_ready(head_ready), .head_seq(head_seq),
    .head_squashed(head_squashed), .commit_ok(commit_ok), .thr_free(thr_free),
    .total_free(total_free)
  );

  function automatic int tfree(int t);
    return int'(thr_free[t*CNTW +: CNTW]);
  endfunction
  function automatic int hseq(int t);
    return int'(head_seq[t*SEQW +: SEQW]);
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int pol, int mask);
    @(negedge clk);
    cfg_policy = 2'(pol); active_mask = NTHR'(mask);
    @(negedge clk);
  endtask

  task automatic alloc(int tid, int seq, int exp_err);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_tid = TIDW'(tid); alloc_seq = SEQW'(seq);
    #1 chk("R7 alloc_err", int'(alloc_err), exp_err);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic complete(int tid, int seq, int sq);
    @(negedge clk);
    done_valid = 1'b1; done_tid = TIDW'(tid); done_seq = SEQW'(seq); done_squash = sq[0];
    @(negedge clk);
    done_valid = 1'b0; done_squash = 1'b0;
  endtask

  task automatic retire(int tid);
    @(negedge clk);
    retire_req = NTHR'(1 << tid);
    @(negedge clk);
    retire_req = '0;
  endtask

  task automatic t_reset();
    chk("R4 reset free0", tfree(0), DEPTH);
    chk("R4 reset free1", tfree(1), DEPTH);
    chk("R5 reset total", int'(total_free), DEPTH);
    chk("R6 reset ready", int'(alloc_ready), 1);
    chk("R8 reset head_ready", int'(head_ready), 0);
    chk("R9 reset commit", int'(commit_ok), 0);
  endtask

  task automatic t_policies();
    @(negedge clk);
    cfg_policy = 2'd1; active_mask = 2'b11;
    #1 chk("R4 limit lag", tfree(0), DEPTH);
    @(negedge clk);
    chk("R2 part both", tfree(0), 4);
    chk("R2 part both t1", tfree(1), 4);
    set_cfg(1, 2'b01); chk("R2 part one", tfree(1), 8);
    set_cfg(1, 2'b00); chk("R2 part none", tfree(0), 4);
    set_cfg(2, 2'b11); chk("R3 thr both", tfree(0), THRESH);
    chk("R3 thr both t1", tfree(1), THRESH);
    set_cfg(2, 2'b10); chk("R3 thr single active", tfree(1), DEPTH);
    chk("R3 thr single inactive", tfree(0), THRESH);
    set_cfg(3, 2'b11); chk("R1 code3 dyn", tfree(0), DEPTH);
    set_cfg(0, 2'b11); chk("R1 dyn", tfree(1), DEPTH);
  endtask

  task automatic t_fill();
    set_cfg(1, 2'b11);
    for (int s = 1; s <= 4; s++) alloc(0, s, 0);
    chk("R6 t0 free", tfree(0), 0);
    chk("R6 total", int'(total_free), 4);
    alloc(0, 5, 1);
    chk("R7 no store total", int'(total_free), 4);
    chk("R10 head seq", hseq(0), 1);
    for (int s = 11; s <= 14; s++) alloc(1, s, 0);
    chk("R6 full total", int'(total_free), 0);
    chk("R6 full ready", int'(alloc_ready), 0);
    alloc(1, 15, 0);
    chk("R6 full no take", int'(total_free), 0);
  endtask

  task automatic t_commit();
    complete(0, 2, 0);
    chk("R8 non-head done", int'(head_ready[0]), 0);
    complete(0, 1, 0);
    chk("R8 head done", int'(head_ready[0]), 1);
    chk("R9 commit", int'(commit_ok), 1);
    set_cfg(1, 2'b10);
    chk("R9 inactive ignored", int'(commit_ok), 0);
    set_cfg(1, 2'b11);
    chk("R9 active again", int'(commit_ok), 1);
  endtask

  task automatic t_retire();
    retire(1);
    chk("R10 unready ignored seq", hseq(1), 11);
    chk("R10 unready ignored total", int'(total_free), 0);
    retire(0);
    chk("R10 order", hseq(0), 2);
    chk("R8 next ready", int'(head_ready[0]), 1);
    retire(0);
    chk("R10 order 2", hseq(0), 3);
    chk("R8 not ready", int'(head_ready[0]), 0);
    chk("R5 total after", int'(total_free), 2);
    chk("R5 t0 free", tfree(0), 2);
  endtask

  task automatic t_squash();
    complete(1, 11, 1);
    chk("R11 squashed", int'(head_squashed[1]), 1);
    chk("R8 squash ready", int'(head_ready[1]), 1);
    retire(1);
    chk("R11 next clean", int'(head_squashed[1]), 0);
    chk("R10 t1 order", hseq(1), 12);
  endtask

  task automatic t_clamp();
    set_cfg(0, 2'b11);
    for (int s = 15; s <= 17; s++) alloc(1, s, 0);
    chk("R6 full again", int'(total_free), 0);
    set_cfg(1, 2'b11);
    chk("R5 clamp t1", tfree(1), 0);
    chk("R5 t0 share", tfree(0), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_policies();
    t_fill();
    t_commit();
    t_retire();
    t_squash();
    t_clamp();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule